// File: doc/BRIEF.md
# SPI Event Flag Controller

This block keeps the event and status flags of an SPI peripheral that runs either as bus master or as slave. The shift engine, the clock generator and the delay counters sit outside it. They report their activity on plain strobe and level inputs: a new received character begins, the receive buffer holds unread data, the transmit holding register is loaded, the transmitter is idle, the slave clock edge is due, and the raw slave select lines.

From these inputs the block keeps four sticky flags: receive overrun, transmit underrun, select asserted and select released. It also tells the shift engine to drop an incoming character that would overwrite unread data. Software clears the flags by writing ones to a small register port.

The same port sets a one-shot end-of-transfer request. This request stays high until the transmitter goes idle. It then clears itself and asks the external delay counters to insert the frame and transfer delays. A per-flag enable register gates the flags onto one registered level interrupt.

Top module: `spi_evt_flags`

## Requirements
- R1: During and after a synchronous reset, `status` reads 0 and `irq`, `rx_drop` and `delay_req` are 0.
- R2: When `master_mode`=0 and `rx_char_start` and `rx_buf_full` are both 1 at a clock edge, status bit 2 (receive overrun) reads 1 after that edge. `rx_drop` is 1 for exactly that one following cycle. If `rx_buf_full`=0, neither happens.
- R3: While `master_mode`=1, neither status bit 2 nor status bit 3 is ever set, and `rx_drop` stays 0.
- R4: When `master_mode`=0 and `tx_idle`=1, `tx_sclk_edge`=1 and `tx_hold_full`=0 at one clock edge, status bit 3 (transmit underrun) reads 1 after that edge. If `tx_hold_full`=1 or `tx_idle`=0, the bit is not set.
- R5: A 1-to-0 transition on any bit of the active-low `sel_n` sets status bit 4 (select asserted) in both modes. The line passes two synchroniser stages and an edge register, so the bit first reads 1 after the third rising edge that follows the change.
- R6: A 0-to-1 transition on any bit of `sel_n` sets status bit 5 (select released) in both modes, with the same three-edge latency. Reset treats every line as high, so no edge is reported when reset ends.
- R7: A write with `reg_addr`=0 clears each of status bits 2 to 5 whose `reg_wdata` bit is 1. Zero data bits leave the flag unchanged. A set event in the same cycle as a clear leaves the flag at 1.
- R8: A write with `reg_addr`=0 and `reg_wdata` bit 7 = 1 sets status bit 7 (forced end of transfer). A 0 in bit 7 has no effect. The bit holds while `tx_idle`=0. After the first edge at which it is 1 and `tx_idle`=1, it reads 0 and `delay_req` is 1 for that one cycle.
- R9: A write with `reg_addr`=1 loads the interrupt enables from `reg_wdata` bits 2 to 5. `irq` becomes 1 one edge after any status bit 2 to 5 is 1 together with its enable. It returns to 0 one edge after no enabled flag remains.
- R10: Status bits 0, 1 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| rx_char_start | input | 1 | Strobe: a received character begins |
| rx_buf_full | input | 1 | Receive buffer holds unread data |
| tx_hold_full | input | 1 | Transmit holding register loaded |
| tx_idle | input | 1 | Transmitter has no activity in progress |
| tx_sclk_edge | input | 1 | Strobe: slave must shift out on this input clock |
| sel_n | input | NSEL | Raw active-low slave select lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | 0 = status, 1 = interrupt enable |
| reg_wdata | input | 8 | Register write data |
| status | output | 8 | Flag word: bit 2 overrun, 3 underrun, 4 select asserted, 5 select released, 7 forced end |
| rx_drop | output | 1 | One-cycle request to discard the incoming character |
| delay_req | output | 1 | One-cycle request for frame and transfer delays |
| irq | output | 1 | Registered level interrupt |

## Verification
Two functions can land in one cycle: a flag can be set by its event at the same edge as a software write clears it. The bench first sets the overrun flag. It then drives a second overrun condition and a write-one-to-clear of bit 2 at the same edge. It expects the flag to stay 1, and a lone clear afterwards must take it to 0. The forced end-of-transfer request meets the same kind of overlap with the idle level, and the bench checks the self-clear edge and the one-cycle delay pulse edge by edge.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int REG_W       = 8;
  localparam int NFLAG       = 4;
  localparam int FLAG_LSB    = 2;
  localparam int IDX_OVR     = 0;
  localparam int IDX_UDR     = 1;
  localparam int IDX_SEL_ON  = 2;
  localparam int IDX_SEL_OFF = 3;
  localparam int BIT_EOT     = 7;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_IRQEN  = 1;
endpackage

// File: rtl/sel_edge_det.sv
module sel_edge_det #(
  parameter int NSEL        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEL-1:0] sel_n,
  output logic            any_on,
  output logic            any_off
);
  logic [NSEL-1:0] sync_q [SYNC_STAGES];
  logic [NSEL-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '1;
    else     sync_q[0] <= sel_n;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '1;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  // Active-low lines: falling level = select asserted
  assign any_on  = |(prev_q & ~sync_q[SYNC_STAGES-1]);
  assign any_off = |(~prev_q & sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/xfer_fault_det.sv
module xfer_fault_det (
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic rx_char_start,
  input  logic rx_buf_full,
  input  logic tx_hold_full,
  input  logic tx_idle,
  input  logic tx_sclk_edge,
  output logic ovr_evt,
  output logic udr_evt,
  output logic rx_drop
);
  logic slave;
  assign slave   = ~master_mode;
  assign ovr_evt = slave & rx_char_start & rx_buf_full;
  assign udr_evt = slave & tx_idle & tx_sclk_edge & ~tx_hold_full;

  always_ff @(posedge clk) begin
    if (rst) rx_drop <= 1'b0;
    else     rx_drop <= ovr_evt;
  end
endmodule

// File: rtl/w1c_flag_bank.sv
module w1c_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_end_ctl.sv
module xfer_end_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic tx_idle,
  output logic eot,
  output logic delay_req
);
  logic done;
  assign done = eot & tx_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      eot       <= 1'b0;
      delay_req <= 1'b0;
    end else begin
      eot       <= req | (eot & ~tx_idle);
      delay_req <= done;
    end
  end
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
  import spi_evt_pkg::*;
#(
  parameter int NSEL        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              rx_char_start,
  input  logic              rx_buf_full,
  input  logic              tx_hold_full,
  input  logic              tx_idle,
  input  logic              tx_sclk_edge,
  input  logic [NSEL-1:0]   sel_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  status,
  output logic              rx_drop,
  output logic              delay_req,
  output logic              irq
);
  logic wr_status, wr_irqen;
  logic ovr_evt, udr_evt, sel_on, sel_off, eot;
  logic [NFLAG-1:0] set_v, clr_v, flags, en_q;
  logic unused_wbits;

  assign wr_status = reg_wr & (reg_addr == ADDR_W'(ADDR_STATUS));
  assign wr_irqen  = reg_wr & (reg_addr == ADDR_W'(ADDR_IRQEN));
  assign unused_wbits = ^{reg_wdata[1:0], reg_wdata[6]};

  sel_edge_det #(.NSEL(NSEL), .SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .sel_n(sel_n), .any_on(sel_on), .any_off(sel_off)
  );

  xfer_fault_det u_fault (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .rx_char_start(rx_char_start), .rx_buf_full(rx_buf_full),
    .tx_hold_full(tx_hold_full), .tx_idle(tx_idle), .tx_sclk_edge(tx_sclk_edge),
    .ovr_evt(ovr_evt), .udr_evt(udr_evt), .rx_drop(rx_drop)
  );

  always_comb begin
    set_v              = '0;
    set_v[IDX_OVR]     = ovr_evt;
    set_v[IDX_UDR]     = udr_evt;
    set_v[IDX_SEL_ON]  = sel_on;
    set_v[IDX_SEL_OFF] = sel_off;
  end
  assign clr_v = {NFLAG{wr_status}} & reg_wdata[FLAG_LSB +: NFLAG];

  w1c_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v), .flags(flags)
  );

  xfer_end_ctl u_end (
    .clk(clk), .rst(rst), .req(wr_status & reg_wdata[BIT_EOT]),
    .tx_idle(tx_idle), .eot(eot), .delay_req(delay_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_irqen) en_q <= reg_wdata[FLAG_LSB +: NFLAG];
      irq <= |(flags & en_q);
    end
  end

  always_comb begin
    status                       = '0;
    status[FLAG_LSB +: NFLAG]    = flags;
    status[BIT_EOT]              = eot;
  end
endmodule

// File: rtl/spi_evt_flags_chk.sv
module spi_evt_flags_chk #(
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              rx_char_start,
  input logic              rx_buf_full,
  input logic              tx_idle,
  input logic              tx_sclk_edge,
  input logic              tx_hold_full,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        status,
  input logic              rx_drop,
  input logic              delay_req,
  input logic              irq
);
  logic wr_st;
  assign wr_st = reg_wr && (reg_addr == '0);

  assert_drop_cause_R2: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> $past(rx_char_start && rx_buf_full && !master_mode));

  assert_ovr_slave_only_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status[2]) |-> $past(!master_mode && rx_char_start && rx_buf_full));

  assert_udr_slave_only_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3]) |-> $past(!master_mode && tx_idle && tx_sclk_edge && !tx_hold_full));

  assert_sel_on_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status[4] && !(wr_st && reg_wdata[4])) |=> status[4]);

  assert_sel_off_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !(wr_st && reg_wdata[5])) |=> status[5]);

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (status[2] && wr_st && reg_wdata[2] && !(!master_mode && rx_char_start && rx_buf_full))
    |=> !status[2]);

  assert_eot_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(status[7]) |-> $past(tx_idle));

  assert_delay_cause_R8: assert property (@(posedge clk) disable iff (rst)
    delay_req |-> $past(status[7] && tx_idle));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(status[5:2] != 4'b0));

  assert_spare_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (status[1:0] == 2'b00) && !status[6]);
endmodule

bind spi_evt_flags spi_evt_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode),
  .rx_char_start(rx_char_start), .rx_buf_full(rx_buf_full),
  .tx_idle(tx_idle), .tx_sclk_edge(tx_sclk_edge), .tx_hold_full(tx_hold_full),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status(status), .rx_drop(rx_drop), .delay_req(delay_req), .irq(irq)
);

// File: tb/tb_spi_evt_flags.sv
`timescale 1ns/1ps
module tb_spi_evt_flags;
  localparam int NSEL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b0, rx_char_start = 1'b0, rx_buf_full = 1'b0;
  logic tx_hold_full = 1'b0, tx_idle = 1'b0, tx_sclk_edge = 1'b0;
  logic [NSEL-1:0] sel_n = '1;
  logic reg_wr = 1'b0;
  logic [0:0] reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] status;
  logic rx_drop, delay_req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_evt_flags #(.NSEL(NSEL)) dut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .rx_char_start(rx_char_start), .rx_buf_full(rx_buf_full),
    .tx_hold_full(tx_hold_full), .tx_idle(tx_idle), .tx_sclk_edge(tx_sclk_edge),
    .sel_n(sel_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(status), .rx_drop(rx_drop), .delay_req(delay_req), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [0:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    chk("R1", "status in reset", status, 8'h00);
    rst = 1'b0;
    tick(4);
    chk("R1", "status after reset", status, 8'h00);
    chk("R1", "irq", irq, 0);
    chk("R1", "rx_drop", rx_drop, 0);
    chk("R1", "delay_req", delay_req, 0);
    chk("R6", "no select edge out of reset", status[5:4], 2'b00);
  endtask

  task automatic t_overrun();
    master_mode = 1'b0;
    rx_char_start = 1'b1; rx_buf_full = 1'b0;
    tick(1);
    rx_char_start = 1'b0;
    chk("R2", "no overrun with empty buffer", status[2], 0);
    rx_char_start = 1'b1; rx_buf_full = 1'b1;
    tick(1);
    rx_char_start = 1'b0;
    chk("R2", "overrun flag", status[2], 1);
    chk("R2", "rx_drop pulse", rx_drop, 1);
    tick(1);
    chk("R2", "rx_drop one cycle", rx_drop, 0);
    chk("R2", "overrun sticky", status[2], 1);
    wr(1'b0, 8'h04);
    chk("R7", "overrun cleared", status[2], 0);
    rx_buf_full = 1'b0;
  endtask

  task automatic t_master_ignored();
    master_mode = 1'b1;
    rx_char_start = 1'b1; rx_buf_full = 1'b1;
    tx_idle = 1'b1; tx_sclk_edge = 1'b1; tx_hold_full = 1'b0;
    tick(1);
    chk("R3", "rx_drop in master", rx_drop, 0);
    tick(1);
    rx_char_start = 1'b0; rx_buf_full = 1'b0; tx_sclk_edge = 1'b0; tx_idle = 1'b0;
    tick(1);
    chk("R3", "no overrun/underrun in master", status[3:2], 2'b00);
    master_mode = 1'b0;
  endtask

  task automatic t_underrun();
    master_mode = 1'b0;
    tx_idle = 1'b1; tx_sclk_edge = 1'b1; tx_hold_full = 1'b1;
    tick(1);
    chk("R4", "no underrun with hold full", status[3], 0);
    tx_idle = 1'b0; tx_hold_full = 1'b0;
    tick(1);
    chk("R4", "no underrun when not idle", status[3], 0);
    tx_idle = 1'b1;
    tick(1);
    tx_sclk_edge = 1'b0; tx_idle = 1'b0;
    chk("R4", "underrun flag", status[3], 1);
    wr(1'b0, 8'h08);
    chk("R7", "underrun cleared", status[3], 0);
  endtask

  task automatic t_select();
    master_mode = 1'b0;
    sel_n = 2'b01;
    tick(2);
    chk("R5", "assert not before third edge", status[4], 0);
    tick(1);
    chk("R5", "assert after third edge", status[4], 1);
    chk("R6", "no release on assert", status[5], 0);
    wr(1'b0, 8'h10);
    chk("R7", "assert flag cleared", status[4], 0);
    master_mode = 1'b1;
    sel_n = 2'b11;
    tick(2);
    chk("R6", "release not before third edge", status[5], 0);
    tick(1);
    chk("R6", "release in master mode", status[5], 1);
    sel_n = 2'b10;
    tick(4);
    chk("R5", "assert on line 0 in master", status[4], 1);
    sel_n = 2'b11;
    tick(4);
    master_mode = 1'b0;
  endtask

  task automatic t_w1c();
    wr(1'b0, 8'h00);
    chk("R7", "zero write keeps flags", status[5:4], 2'b11);
    wr(1'b0, 8'h10);
    chk("R7", "selective clear", status[5:4], 2'b10);
    wr(1'b0, 8'h20);
    chk("R7", "second clear", status[5:4], 2'b00);
    rx_char_start = 1'b1; rx_buf_full = 1'b1;
    tick(1);
    chk("R7", "overrun set before race", status[2], 1);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h04;
    tick(1);
    reg_wr = 1'b0; reg_wdata = 8'h00; rx_char_start = 1'b0; rx_buf_full = 1'b0;
    chk("R7", "set beats clear", status[2], 1);
    wr(1'b0, 8'h04);
    chk("R7", "clear after race", status[2], 0);
  endtask

  task automatic t_eot();
    tx_idle = 1'b0;
    wr(1'b0, 8'h00);
    chk("R8", "zero bit7 no effect", status[7], 0);
    wr(1'b0, 8'h80);
    chk("R8", "forced end set", status[7], 1);
    tick(3);
    chk("R8", "held while busy", status[7], 1);
    chk("R8", "no delay while busy", delay_req, 0);
    tx_idle = 1'b1;
    tick(1);
    chk("R8", "self clear on idle", status[7], 0);
    chk("R8", "delay pulse", delay_req, 1);
    tick(1);
    chk("R8", "delay one cycle", delay_req, 0);
    tx_idle = 1'b0;
    chk("R10", "spare bits zero", {status[6], status[1:0]}, 3'b000);
  endtask

  task automatic t_irq();
    wr(1'b1, 8'h08);
    chk("R9", "enable write leaves status", status, 8'h00);
    rx_char_start = 1'b1; rx_buf_full = 1'b1;
    tick(1);
    rx_char_start = 1'b0; rx_buf_full = 1'b0;
    tick(2);
    chk("R9", "disabled flag no irq", irq, 0);
    tx_idle = 1'b1; tx_sclk_edge = 1'b1;
    tick(1);
    tx_idle = 1'b0; tx_sclk_edge = 1'b0;
    chk("R9", "irq one edge late", irq, 0);
    tick(1);
    chk("R9", "irq raised", irq, 1);
    wr(1'b0, 8'h08);
    chk("R9", "irq registered after clear", irq, 1);
    tick(1);
    chk("R9", "irq dropped", irq, 0);
    wr(1'b0, 8'h04);
    chk("R9", "flags empty", status, 8'h00);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_overrun();
    t_master_ignored();
    t_underrun();
    t_select();
    t_w1c();
    t_eot();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule